// File: doc/BRIEF.md
# Circular Trace Capture Buffer

This block records a stream of 32-bit trace frames into a circular on-chip RAM. It stores frames only while capture is enabled. A trigger pulse starts a post-trigger countdown. When that countdown expires, recording stops on its own, so the RAM holds a chosen amount of history before the trigger and a chosen amount after it. The block keeps a write pointer, a read pointer, the countdown, a control word and four status flags. All of them are reached through a small register port that selects a register by a 3-bit index.

A typical session runs as follows:
1. Software loads the countdown. The usual value is the buffer depth times a percentage from 2 to 100, divided by 100; 50 percent is the usual default.
2. Software clears the write pointer.
3. Software sets the enable bit.
4. Software polls the status until acquisition completes.
5. Software reads the frames back. If the buffer wrapped, the oldest frame sits at the write pointer. If it did not wrap, the valid frames run from entry 0 up to the write pointer minus one. Each read of the data register returns the frame at the read pointer and then moves the read pointer forward by one.

Accepted frames pass through a one-frame staging register before the RAM write. The drain-empty flag shows whether that stage is empty.

Top module: `tcb_top`

## Requirements
- R1: After reset:
  - the control word, both pointers and the countdown read 0;
  - Full, Triggered and Done are 0;
  - Empty is 1;
  - `capturing` is 0.
- R2: Register indices are 0 control, 1 status, 2 depth, 3 frame width, 4 RAM data, 5 write pointer, 6 read pointer and 7 post-trigger countdown. Depth reads the `DEPTH` parameter and frame width reads 32. A read request returns its data, with `reg_rvalid` high, in the cycle after the request.
- R3: While control bit 0 is 1 and Done is 0, every valid frame is stored at the write pointer. The write pointer then advances by one, modulo `DEPTH`.
- R4: Status bit 0 (Full) is set when the write pointer wraps from `DEPTH-1` to 0. It stays set until the next capture start.
- R5: A trigger pulse while capturing sets status bit 1 (Triggered). The frame accepted in the trigger cycle counts against the countdown, and so does every later frame. Status bit 2 (Done) is set in these cases:
  - the countdown steps from 1 to 0;
  - the trigger arrives while the countdown is already 0; the frame in that cycle is still stored.

  Once Done is set, frames are no longer stored and `capturing` is low, even though control bit 0 stays 1.
- R6: A read of index 4 returns the frame at the read pointer and advances the read pointer by one, modulo `DEPTH`. A read of any other index leaves the read pointer unchanged.
- R7: In each cycle, status bit 3 (Empty) is the inverse of whether a frame was accepted in the previous cycle. It goes high one cycle after the final frame is written to RAM.
- R8: Writing the control word with bit 0 set while the enable was clear is a capture start, and it clears Full, Triggered and Done. Writing 0 to the control word stops capture: later frames are dropped and the write pointer does not move.
- R9: Control bit 1 (the demultiplexed-port mode bit) is stored and reads back, and it has no effect on capture. Writes to indices 1, 2, 3 and 4 are ignored.
- R10: Register writes to the write pointer, the read pointer and the countdown take effect for the following operations.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| frame_valid | input | 1 | Frame strobe |
| frame_data | input | 32 | Trace frame |
| trig_in | input | 1 | Trigger pulse |
| reg_en | input | 1 | Register access request |
| reg_we | input | 1 | 1 = write, 0 = read |
| reg_idx | input | 3 | Register index |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data |
| reg_rvalid | output | 1 | Read data valid |
| capturing | output | 1 | Frames are being accepted |
| stat_full | output | 1 | Write pointer has wrapped |
| stat_trig | output | 1 | Trigger seen |
| stat_done | output | 1 | Acquisition complete |
| stat_empty | output | 1 | Staging stage is empty |

## Verification
The following properties are checked on every cycle:
- Full and Triggered stay set until a capture start.
- Done freezes the write pointer once the staging stage has drained.
- Empty tracks the previous cycle's frame acceptance.
- A capture start clears the three flags.
- Each data read moves the read pointer by exactly one, and other reads leave it alone.

Only the bench scenarios can show the following:
- the frames stored are the frames that were sent;
- the countdown stops at the right frame for a given trigger position;
- readback after a wrap starts at the oldest frame.

// File: rtl/tcb_pkg.sv
`timescale 1ns/1ps
package tcb_pkg;
  localparam int unsigned IDX_W = 3;

  typedef enum logic [IDX_W-1:0] {
    IDX_CTRL  = 3'd0,
    IDX_STAT  = 3'd1,
    IDX_DEPTH = 3'd2,
    IDX_WIDTH = 3'd3,
    IDX_DATA  = 3'd4,
    IDX_WPTR  = 3'd5,
    IDX_RPTR  = 3'd6,
    IDX_TCNT  = 3'd7
  } reg_idx_e;

  // status bit positions
  localparam int unsigned ST_FULL  = 0;
  localparam int unsigned ST_TRIG  = 1;
  localparam int unsigned ST_DONE  = 2;
  localparam int unsigned ST_EMPTY = 3;
  localparam int unsigned ST_W     = 4;
endpackage

// File: rtl/tcb_ram.sv
`timescale 1ns/1ps
// Simple dual-port RAM, synchronous read, written for block RAM inference.
module tcb_ram #(
  parameter int unsigned DW    = 32,
  parameter int unsigned DEPTH = 64,
  localparam int unsigned AW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic          re,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  always_ff @(posedge clk) begin
    if (re) rdata <= mem[raddr];
  end
endmodule

// File: rtl/tcb_capture.sv
`timescale 1ns/1ps
// Frame acceptance, staging, write pointer, trigger countdown and flags.
module tcb_capture #(
  parameter int unsigned DW    = 32,
  parameter int unsigned DEPTH = 64,
  localparam int unsigned AW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          cap_en,
  input  logic          start,
  input  logic          frame_valid,
  input  logic [DW-1:0] frame_data,
  input  logic          trig_in,
  input  logic          wptr_we,
  input  logic          tcnt_we,
  input  logic [DW-1:0] wdata,
  output logic          ram_we,
  output logic [AW-1:0] ram_waddr,
  output logic [DW-1:0] ram_wdata,
  output logic [AW-1:0] wr_ptr,
  output logic [DW-1:0] tcnt,
  output logic          full,
  output logic          triggered,
  output logic          done,
  output logic          empty,
  output logic          active
);
  logic          stage_v;
  logic [DW-1:0] stage_d;
  logic          acc, trig_hit, trig_eff;

  assign active   = cap_en && !done;
  assign acc      = frame_valid && active;
  assign trig_hit = trig_in && active;
  assign trig_eff = triggered || trig_hit;

  always_ff @(posedge clk) begin
    if (rst) begin
      stage_v   <= 1'b0;
      stage_d   <= '0;
      wr_ptr    <= '0;
      full      <= 1'b0;
      triggered <= 1'b0;
      done      <= 1'b0;
      tcnt      <= '0;
    end else begin
      stage_v <= acc;
      if (acc) stage_d <= frame_data;

      if (stage_v) begin
        if (wr_ptr == AW'(DEPTH - 1)) begin
          wr_ptr <= '0;
          full   <= 1'b1;
        end else begin
          wr_ptr <= wr_ptr + AW'(1);
        end
      end
      if (wptr_we) wr_ptr <= wdata[AW-1:0];

      if (trig_hit) triggered <= 1'b1;

      if (trig_eff && !done) begin
        if (tcnt == '0) begin
          done <= 1'b1;
        end else if (acc) begin
          tcnt <= tcnt - DW'(1);
          if (tcnt == DW'(1)) done <= 1'b1;
        end
      end
      if (tcnt_we) tcnt <= wdata;

      if (start) begin
        full      <= 1'b0;
        triggered <= 1'b0;
        done      <= 1'b0;
      end
    end
  end

  assign ram_we    = stage_v;
  assign ram_waddr = wr_ptr;
  assign ram_wdata = stage_d;
  assign empty     = !stage_v;
endmodule

// File: rtl/tcb_regs.sv
`timescale 1ns/1ps
// Register port: control word, read pointer, decode and read-back mux.
module tcb_regs
  import tcb_pkg::*;
#(
  parameter int unsigned DW    = 32,
  parameter int unsigned DEPTH = 64,
  localparam int unsigned AW   = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              reg_en,
  input  logic              reg_we,
  input  logic [IDX_W-1:0]  reg_idx,
  input  logic [AW-1:0]     wdata_lo,
  input  logic [ST_W-1:0]   status,
  input  logic [AW-1:0]     wr_ptr,
  input  logic [DW-1:0]     tcnt,
  input  logic [DW-1:0]     ram_q,
  output logic              cap_en,
  output logic              start,
  output logic              wptr_we,
  output logic              tcnt_we,
  output logic              ram_re,
  output logic [AW-1:0]     rd_ptr,
  output logic [DW-1:0]     reg_rdata,
  output logic              reg_rvalid
);
  logic [1:0]    ctrl_q;
  logic          wr_hit, rd_hit, sel_data_q;
  logic [DW-1:0] val_q, mux_val;

  assign wr_hit  = reg_en && reg_we;
  assign rd_hit  = reg_en && !reg_we;
  assign start   = wr_hit && (reg_idx == IDX_CTRL) && wdata_lo[0] && !ctrl_q[0];
  assign wptr_we = wr_hit && (reg_idx == IDX_WPTR);
  assign tcnt_we = wr_hit && (reg_idx == IDX_TCNT);
  assign ram_re  = rd_hit && (reg_idx == IDX_DATA);
  assign cap_en  = ctrl_q[0];

  always_comb begin
    mux_val = '0;
    case (reg_idx)
      IDX_CTRL:  mux_val = DW'(ctrl_q);
      IDX_STAT:  mux_val = DW'(status);
      IDX_DEPTH: mux_val = DW'(DEPTH);
      IDX_WIDTH: mux_val = DW'(DW);
      IDX_WPTR:  mux_val = DW'(wr_ptr);
      IDX_RPTR:  mux_val = DW'(rd_ptr);
      IDX_TCNT:  mux_val = tcnt;
      default:   mux_val = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl_q     <= '0;
      rd_ptr     <= '0;
      reg_rvalid <= 1'b0;
      sel_data_q <= 1'b0;
      val_q      <= '0;
    end else begin
      reg_rvalid <= rd_hit;
      sel_data_q <= ram_re;
      if (rd_hit) val_q <= mux_val;
      if (wr_hit && reg_idx == IDX_CTRL) ctrl_q <= wdata_lo[1:0];
      if (wr_hit && reg_idx == IDX_RPTR) rd_ptr <= wdata_lo;
      if (ram_re) rd_ptr <= (rd_ptr == AW'(DEPTH - 1)) ? '0 : rd_ptr + AW'(1);
    end
  end

  assign reg_rdata = sel_data_q ? ram_q : val_q;
endmodule

// File: rtl/tcb_top.sv
`timescale 1ns/1ps
module tcb_top
  import tcb_pkg::*;
#(
  parameter int unsigned DEPTH = 64,
  localparam int unsigned DW   = 32,
  localparam int unsigned AW   = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             frame_valid,
  input  logic [DW-1:0]    frame_data,
  input  logic             trig_in,
  input  logic             reg_en,
  input  logic             reg_we,
  input  logic [IDX_W-1:0] reg_idx,
  input  logic [DW-1:0]    reg_wdata,
  output logic [DW-1:0]    reg_rdata,
  output logic             reg_rvalid,
  output logic             capturing,
  output logic             stat_full,
  output logic             stat_trig,
  output logic             stat_done,
  output logic             stat_empty
);
  logic          cap_en, cap_start, wptr_we, tcnt_we, ram_re, ram_we;
  logic [AW-1:0] wr_ptr, rd_ptr, ram_waddr;
  logic [DW-1:0] ram_wdata, ram_q, tcnt;
  logic [ST_W-1:0] status;

  always_comb begin
    status           = '0;
    status[ST_FULL]  = stat_full;
    status[ST_TRIG]  = stat_trig;
    status[ST_DONE]  = stat_done;
    status[ST_EMPTY] = stat_empty;
  end

  tcb_capture #(.DW(DW), .DEPTH(DEPTH)) u_cap (
    .clk(clk), .rst(rst), .cap_en(cap_en), .start(cap_start),
    .frame_valid(frame_valid), .frame_data(frame_data), .trig_in(trig_in),
    .wptr_we(wptr_we), .tcnt_we(tcnt_we), .wdata(reg_wdata),
    .ram_we(ram_we), .ram_waddr(ram_waddr), .ram_wdata(ram_wdata),
    .wr_ptr(wr_ptr), .tcnt(tcnt), .full(stat_full), .triggered(stat_trig),
    .done(stat_done), .empty(stat_empty), .active(capturing)
  );

  tcb_ram #(.DW(DW), .DEPTH(DEPTH)) u_ram (
    .clk(clk), .we(ram_we), .waddr(ram_waddr), .wdata(ram_wdata),
    .re(ram_re), .raddr(rd_ptr), .rdata(ram_q)
  );

  tcb_regs #(.DW(DW), .DEPTH(DEPTH)) u_regs (
    .clk(clk), .rst(rst), .reg_en(reg_en), .reg_we(reg_we), .reg_idx(reg_idx),
    .wdata_lo(reg_wdata[AW-1:0]), .status(status), .wr_ptr(wr_ptr), .tcnt(tcnt),
    .ram_q(ram_q), .cap_en(cap_en), .start(cap_start), .wptr_we(wptr_we),
    .tcnt_we(tcnt_we), .ram_re(ram_re), .rd_ptr(rd_ptr),
    .reg_rdata(reg_rdata), .reg_rvalid(reg_rvalid)
  );
endmodule

// File: rtl/tcb_checker.sv
`timescale 1ns/1ps
module tcb_checker
  import tcb_pkg::*;
#(
  parameter int unsigned DEPTH = 64,
  localparam int unsigned AW   = $clog2(DEPTH)
) (
  input logic             clk,
  input logic             rst,
  input logic             frame_valid,
  input logic             reg_en,
  input logic             reg_we,
  input logic [IDX_W-1:0] reg_idx,
  input logic             reg_rvalid,
  input logic             capturing,
  input logic             stat_full,
  input logic             stat_trig,
  input logic             stat_done,
  input logic             stat_empty,
  input logic             cap_start,
  input logic             wptr_we,
  input logic [AW-1:0]    wr_ptr,
  input logic [AW-1:0]    rd_ptr
);
  p_rvalid_r2: assert property (@(posedge clk) disable iff (rst)
    (reg_en && !reg_we) |=> reg_rvalid);

  p_full_sticky_r4: assert property (@(posedge clk) disable iff (rst)
    (stat_full && !cap_start) |=> stat_full);

  p_trig_sticky_r5: assert property (@(posedge clk) disable iff (rst)
    (stat_trig && !cap_start) |=> stat_trig);

  p_done_gates_r5: assert property (@(posedge clk) disable iff (rst)
    stat_done |-> !capturing);

  p_done_freeze_r5: assert property (@(posedge clk) disable iff (rst)
    (stat_done && stat_empty && !wptr_we) |=> $stable(wr_ptr));

  p_data_adv_r6: assert property (@(posedge clk) disable iff (rst)
    (reg_en && !reg_we && reg_idx == IDX_DATA) |=>
      rd_ptr == (($past(rd_ptr) == AW'(DEPTH - 1)) ? '0 : $past(rd_ptr) + AW'(1)));

  p_other_hold_r6: assert property (@(posedge clk) disable iff (rst)
    (reg_en && !reg_we && reg_idx != IDX_DATA) |=> $stable(rd_ptr));

  p_empty_low_r7: assert property (@(posedge clk) disable iff (rst)
    (frame_valid && capturing) |=> !stat_empty);

  p_empty_high_r7: assert property (@(posedge clk) disable iff (rst)
    !(frame_valid && capturing) |=> stat_empty);

  p_start_clear_r8: assert property (@(posedge clk) disable iff (rst)
    cap_start |=> (!stat_full && !stat_trig && !stat_done));
endmodule

bind tcb_top tcb_checker #(.DEPTH(DEPTH)) u_chk (
  .clk(clk), .rst(rst), .frame_valid(frame_valid), .reg_en(reg_en),
  .reg_we(reg_we), .reg_idx(reg_idx), .reg_rvalid(reg_rvalid),
  .capturing(capturing), .stat_full(stat_full), .stat_trig(stat_trig),
  .stat_done(stat_done), .stat_empty(stat_empty), .cap_start(cap_start),
  .wptr_we(wptr_we), .wr_ptr(wr_ptr), .rd_ptr(rd_ptr)
);

// File: tb/tcb_top_tb_top.sv
`timescale 1ns/1ps
module tcb_top_tb_top;
  localparam int D = 64;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic rst, frame_valid, trig_in, reg_en, reg_we;
  logic [31:0] frame_data, reg_wdata, reg_rdata;
  logic [2:0] reg_idx;
  logic reg_rvalid, capturing, stat_full, stat_trig, stat_done, stat_empty;

  tcb_top #(.DEPTH(D)) dut_i (
    .clk(clk), .rst(rst), .frame_valid(frame_valid), .frame_data(frame_data),
    .trig_in(trig_in), .reg_en(reg_en), .reg_we(reg_we), .reg_idx(reg_idx),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .reg_rvalid(reg_rvalid),
    .capturing(capturing), .stat_full(stat_full), .stat_trig(stat_trig),
    .stat_done(stat_done), .stat_empty(stat_empty)
  );

  int checks = 0;
  int errors = 0;

  // bench model of the requirements
  logic [31:0] mmem [D];
  int   m_wp = 0, m_rp = 0;
  logic [31:0] m_cnt = 0;
  logic [1:0]  m_ctrl = 0;
  bit   m_full = 0, m_trig = 0, m_done = 0;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wr(input int idx, input logic [31:0] d);
    reg_en = 1'b1; reg_we = 1'b1; reg_idx = idx[2:0]; reg_wdata = d;
    @(negedge clk);
    reg_en = 1'b0; reg_we = 1'b0;
    case (idx)
      0: begin
        if (d[0] && !m_ctrl[0]) begin m_full = 0; m_trig = 0; m_done = 0; end
        m_ctrl = d[1:0];
      end
      5: m_wp = int'(d % D);
      6: m_rp = int'(d % D);
      7: m_cnt = d;
      default: ;
    endcase
  endtask

  task automatic rd(input int idx, output logic [31:0] q);
    reg_en = 1'b1; reg_we = 1'b0; reg_idx = idx[2:0];
    @(negedge clk);
    reg_en = 1'b0;
    chk("R2 rvalid", {31'b0, reg_rvalid}, 32'd1);
    q = reg_rdata;
    if (idx == 4) m_rp = (m_rp + 1) % D;
  endtask

  function automatic logic [31:0] exp_status();
    return {28'b0, 1'b1, m_done, m_trig, m_full};
  endfunction

  // drive n cycles; frames valid with probability dens percent, trigger at cycle tat
  task automatic feed(input int n, input int tat, input int dens);
    for (int i = 0; i < n; i++) begin
      bit v, t, act, acc, hit, teff;
      logic [31:0] d;
      v = (($urandom % 100) < dens);
      t = (i == tat);
      d = $urandom;
      act = m_ctrl[0] && !m_done;
      chk("R5 capturing", {31'b0, capturing}, {31'b0, act});
      frame_valid = v; trig_in = t; frame_data = d;
      acc = v && act; hit = t && act; teff = m_trig || hit;
      if (acc) begin
        mmem[m_wp] = d;
        if (m_wp == D - 1) begin m_wp = 0; m_full = 1; end else m_wp++;
      end
      if (teff && !m_done) begin
        if (m_cnt == 0) m_done = 1;
        else if (acc) begin
          if (m_cnt == 1) m_done = 1;
          m_cnt = m_cnt - 1;
        end
      end
      if (hit) m_trig = 1;
      @(negedge clk);
      chk("R7 empty", {31'b0, stat_empty}, {31'b0, !acc});
    end
    frame_valid = 1'b0; trig_in = 1'b0;
    @(negedge clk);
    @(negedge clk);
  endtask

  task automatic check_all(input string tag);
    logic [31:0] q;
    int first, n;
    rd(1, q); chk({tag, " status"}, q, exp_status());
    rd(5, q); chk({tag, " R3 wptr"}, q, m_wp);
    rd(7, q); chk({tag, " R5 count"}, q, m_cnt);
    first = m_full ? m_wp : 0;
    n     = m_full ? D : m_wp;
    wr(6, first);
    for (int k = 0; k < n; k++) begin
      rd(4, q); chk({tag, " R6 frame"}, q, mmem[(first + k) % D]);
    end
    rd(6, q); chk({tag, " R6 rptr"}, q, (first + n) % D);
  endtask

  initial begin
    #(20ns * 150000);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] q;
    void'($urandom(32'd4711));
    rst = 1'b1; frame_valid = 0; trig_in = 0; frame_data = 0;
    reg_en = 0; reg_we = 0; reg_idx = 0; reg_wdata = 0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);

    // R1 reset state
    chk("R1 empty port", {31'b0, stat_empty}, 32'd1);
    chk("R1 capturing", {31'b0, capturing}, 32'd0);
    rd(0, q); chk("R1 ctrl", q, 0);
    rd(1, q); chk("R1 status", q, 32'h8);
    rd(5, q); chk("R1 wptr", q, 0);
    rd(6, q); chk("R1 rptr", q, 0);
    rd(7, q); chk("R1 count", q, 0);
    // R2 constants
    rd(2, q); chk("R2 depth", q, D);
    rd(3, q); chk("R2 width", q, 32);

    // R5 directed: count 3, trigger on 5th frame -> 7 frames stored
    wr(7, 3); wr(5, 0); wr(0, 1);
    feed(10, 4, 100);
    rd(5, q); chk("R5 stop point", q, 7);
    chk("R5 done port", {31'b0, stat_done}, 32'd1);
    chk("R5 gated", {31'b0, capturing}, 32'd0);
    check_all("R5 directed");

    // R8 start clears, R5 zero count at trigger
    wr(0, 0); wr(7, 0); wr(5, 0); wr(0, 1);
    rd(1, q); chk("R8 start clears", q, 32'h8);
    feed(5, 2, 100);
    rd(5, q); chk("R5 zero count", q, 3);
    check_all("R5 zero");

    // R4 wrap, oldest frame at write pointer
    wr(0, 0); wr(7, 1000); wr(5, 0); wr(0, 1);
    feed(100, -1, 100);
    rd(5, q); chk("R4 wrapped wptr", q, 36);
    chk("R4 full port", {31'b0, stat_full}, 32'd1);
    check_all("R4 wrap");
    // R8 stop
    wr(0, 0);
    feed(10, -1, 100);
    rd(5, q); chk("R8 stopped wptr", q, 36);

    // R9 mode bit and read-only indices
    wr(0, 3);
    rd(0, q); chk("R9 ctrl readback", q, 3);
    wr(0, 0);
    wr(1, 32'hF); rd(1, q); chk("R9 status ro", q, exp_status());
    wr(2, 5);     rd(2, q); chk("R9 depth ro", q, D);
    wr(3, 7);     rd(3, q); chk("R9 width ro", q, 32);

    // R6/R10 non-data reads keep the read pointer
    wr(6, 5);
    rd(1, q); rd(2, q); rd(7, q);
    rd(6, q); chk("R10 R6 rptr held", q, 5);

    // R3 random runs
    for (int run = 0; run < 4; run++) begin
      int n, dens;
      n    = 20 + int'($urandom % 150);
      dens = 30 + int'($urandom % 60);
      wr(0, 0); wr(7, $urandom % (D + 10)); wr(5, 0); wr(0, 1);
      feed(n, int'($urandom % n), dens);
      wr(0, 0);
      check_all("R3 random");
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule